// File: doc/BRIEF.md
# Bitfield Move Execution Unit

This unit carries out one bitfield move per issued operation. A source operand is shifted by a signed amount. A contiguous mask is built from a low bit index and an exclusive high bit index. Mask positions are then taken from the shifted source and all other positions from a second "merge" operand. With a zero merge operand the operation extracts a field. With a live merge operand it inserts one. With both, it relocates a field from any position to any other in a single step.

The unit has two widths. In 64-bit mode the six-bit indices are taken modulo 64, so a high index below the low index gives a mask that wraps through bit 63 into bit 0. In 128-bit mode one extension bit widens the indices to seven bits. The bit is applied asymmetrically, which gives up wrap-around masks at that width. Operands are 128 bits wide. In 64-bit mode only their lower halves matter. The result is registered and appears one cycle after an issue strobe.

Top module: `bitfield_move_unit`

## Requirements
- R1: When `op_valid` is high on a clock edge, `res_valid` is high and `res_data` holds that operation's result after the next edge. When `op_valid` is low, `res_valid` drops and `res_data` keeps its previous value.
- R2: The shift is an 8-bit two's-complement value. A positive value moves source bits toward the MSB and a negative value moves them toward the LSB. Vacated positions fill with zero, and bits pushed past either end of the active width are discarded. A magnitude of at least the active width (64 or 128) yields an all-zero shifted source.
- R3: In 64-bit mode with `fld_hi` > `fld_lo`, the mask covers bits `fld_lo` through `fld_hi`-1. For example, shift 36, low 48, high 56 moves source bits 19..12 into bits 55..48, and shift -12, low 0, high 8 with a zero merge operand extracts source bits 19..12 into bits 7..0.
- R4: In 64-bit mode with `fld_hi` < `fld_lo`, the mask covers bits `fld_lo`..63 together with bits 0..`fld_hi`-1. A high index of 0 therefore selects `fld_lo` up to bit 63.
- R5: When `fld_lo` equals `fld_hi`, the mask is empty and the result equals the merge operand within the active width.
- R6: Every result bit inside the mask equals the shifted source bit, and every bit outside it equals the merge operand bit.
- R7: In 64-bit mode (`wide_mode` = 0), bits 127..64 of both operands and the `fld_ext` bit have no effect, and result bits 127..64 are zero.
- R8: In 128-bit mode with `fld_hi` >= `fld_lo`, `fld_ext` is prepended as bit 6 of both indices. The mask is then bits {ext,lo} through {ext,hi}-1.
- R9: In 128-bit mode with `fld_hi` < `fld_lo`, `fld_ext` is prepended to the high index only and the low index stays below 64. With `fld_ext` = 0 the mask is empty. With `fld_ext` = 1 it spans `fld_lo` through 64+`fld_hi`-1, and it never wraps.
- R10: While `rst` is high, `res_valid` and `res_data` clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue strobe for one operation |
| wide_mode | input | 1 | 0 selects 64-bit mode, 1 selects 128-bit mode |
| src_data | input | 128 | Operand that is shifted |
| mrg_data | input | 128 | Operand merged outside the mask |
| shift_amt | input | 8 | Signed shift, positive toward the MSB |
| fld_lo | input | 6 | Low bit index of the field (inclusive) |
| fld_hi | input | 6 | High bit index of the field (exclusive) |
| fld_ext | input | 1 | Index extension bit for 128-bit mode |
| res_valid | output | 1 | Result valid, one cycle after issue |
| res_data | output | 128 | Merged result |

## Verification
Shift discard and mask selection act in the same cycle. The hardest overlap is a wrapping or high-reaching mask that covers positions whose source bits were shifted away, so those positions must come out as zero rather than as merge data. The bench provokes this with wrap masks under large left and right shifts, and with shifts at or beyond the active width. It also issues many random back-to-back operations with mixed modes. Each result is judged bit by bit against an independent reference that walks each destination position and looks up its source position.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
  typedef enum logic {
    MODE_64  = 1'b0,
    MODE_128 = 1'b1
  } bfm_mode_e;

  // Decoded index pair with wrap flag
  typedef struct packed {
    logic [6:0] lo_pos;
    logic [6:0] hi_pos;
    logic       wrap;
  } bfm_range_t;
endpackage

// File: rtl/bfm_shifter.sv
module bfm_shifter #(
  parameter int DATA_W  = 128,
  parameter int SHIFT_W = 8
) (
  input  logic                      mode_wide,
  input  logic [DATA_W-1:0]         src,
  input  logic signed [SHIFT_W-1:0] amt,
  output logic [DATA_W-1:0]         shifted
);
  localparam int HALF_W = DATA_W / 2;

  logic                neg;
  logic [SHIFT_W-1:0]  mag;
  logic [DATA_W-1:0]   src_eff;
  logic [DATA_W-1:0]   raw;

  always_comb begin
    neg     = amt[SHIFT_W-1];
    // two's-complement magnitude; -min yields min as unsigned, which is correct
    mag     = neg ? (~amt + {{(SHIFT_W-1){1'b0}}, 1'b1}) : amt;
    src_eff = mode_wide ? src : {{HALF_W{1'b0}}, src[HALF_W-1:0]};
    raw     = neg ? (src_eff >> mag) : (src_eff << mag);
    shifted = mode_wide ? raw : {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
  end
endmodule

// File: rtl/bfm_mask_gen.sv
module bfm_mask_gen
  import bfm_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int IDX_W  = 6
) (
  input  logic              mode_wide,
  input  logic [IDX_W-1:0]  lo_idx,
  input  logic [IDX_W-1:0]  hi_idx,
  input  logic              ext_bit,
  output logic [DATA_W-1:0] mask
);
  localparam int HALF_W = DATA_W / 2;
  localparam int POS_W  = IDX_W + 1;

  bfm_range_t rng;
  logic       hi_ge_lo;

  always_comb begin
    hi_ge_lo = (hi_idx >= lo_idx);
    if (mode_wide) begin
      // extension applied to both only when the field is ordered
      rng.lo_pos = hi_ge_lo ? {ext_bit, lo_idx} : {1'b0, lo_idx};
      rng.hi_pos = {ext_bit, hi_idx};
      rng.wrap   = 1'b0;
    end else begin
      rng.lo_pos = {1'b0, lo_idx};
      rng.hi_pos = {1'b0, hi_idx};
      rng.wrap   = ~hi_ge_lo;
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic [POS_W:0] BIT_POS = (POS_W+1)'(i);
    logic ge_lo, lt_hi, active;
    always_comb begin
      ge_lo   = ({1'b0, rng.lo_pos} <= BIT_POS);
      lt_hi   = (BIT_POS < {1'b0, rng.hi_pos});
      active  = (i < HALF_W) || mode_wide;
      mask[i] = active & (rng.wrap ? (ge_lo | lt_hi) : (ge_lo & lt_hi));
    end
  end
endmodule

// File: rtl/bfm_merge.sv
module bfm_merge #(
  parameter int DATA_W = 128
) (
  input  logic              mode_wide,
  input  logic [DATA_W-1:0] shifted,
  input  logic [DATA_W-1:0] mrg,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] merged
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] mrg_eff;

  always_comb begin
    mrg_eff = mode_wide ? mrg : {{HALF_W{1'b0}}, mrg[HALF_W-1:0]};
    merged  = (mrg_eff & ~mask) | (shifted & mask);
  end
endmodule

// File: rtl/bitfield_move_unit.sv
module bitfield_move_unit
  import bfm_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int IDX_W   = 6,
  parameter int SHIFT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid,
  input  logic               wide_mode,
  input  logic [DATA_W-1:0]  src_data,
  input  logic [DATA_W-1:0]  mrg_data,
  input  logic [SHIFT_W-1:0] shift_amt,
  input  logic [IDX_W-1:0]   fld_lo,
  input  logic [IDX_W-1:0]   fld_hi,
  input  logic               fld_ext,
  output logic               res_valid,
  output logic [DATA_W-1:0]  res_data
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] shifted_w;
  logic [DATA_W-1:0] mask_w;
  logic [DATA_W-1:0] merged_w;
  logic [DATA_W-1:0] width_mask;
  bfm_mode_e         mode_q;

  bfm_shifter #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) shf_i (
    .mode_wide (wide_mode),
    .src       (src_data),
    .amt       (shift_amt),
    .shifted   (shifted_w)
  );

  bfm_mask_gen #(.DATA_W(DATA_W), .IDX_W(IDX_W)) msk_i (
    .mode_wide (wide_mode),
    .lo_idx    (fld_lo),
    .hi_idx    (fld_hi),
    .ext_bit   (fld_ext),
    .mask      (mask_w)
  );

  bfm_merge #(.DATA_W(DATA_W)) mrg_i (
    .mode_wide (wide_mode),
    .shifted   (shifted_w),
    .mrg       (mrg_data),
    .mask      (mask_w),
    .merged    (merged_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      mode_q    <= MODE_64;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_data <= merged_w;
        mode_q   <= wide_mode ? MODE_128 : MODE_64;
      end
    end
  end

  assign width_mask = wide_mode ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

  // R1: issue produces a result one cycle later
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);
  // R1: idle cycle drops valid and holds data
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!res_valid && $stable(res_data)));
  // R5: equal indices give an empty mask
  a_r5_empty_mask: assert property (@(posedge clk) disable iff (rst)
    (op_valid && fld_lo == fld_hi) |-> (mask_w == '0));
  // R6: bits outside the mask come from the merge operand
  a_r6_outside_mask: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> (((merged_w ^ mrg_data) & ~mask_w & width_mask) == '0));
  // R6: bits inside the mask come from the shifted source
  a_r6_inside_mask: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> (((merged_w ^ shifted_w) & mask_w) == '0));
  // R7: 64-bit results have a zero upper half
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (res_valid && mode_q == MODE_64) |-> (res_data[DATA_W-1:HALF_W] == '0));
  // R10: reset clears the outputs
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (!res_valid && res_data == '0));
endmodule

// File: tb/bitfield_move_unit_tb_top.sv
`timescale 1ns/1ps
module bitfield_move_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_valid = 1'b0;
  logic         wide_mode = 1'b0;
  logic [127:0] src_data = '0;
  logic [127:0] mrg_data = '0;
  logic [7:0]   shift_amt = '0;
  logic [5:0]   fld_lo = '0;
  logic [5:0]   fld_hi = '0;
  logic         fld_ext = 1'b0;
  logic         res_valid;
  logic [127:0] res_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [127:0] exp_q[$];
  string        tag_q[$];
  logic [127:0] last_exp = '0;

  always #2 clk = ~clk;

  bitfield_move_unit dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .wide_mode(wide_mode),
    .src_data(src_data), .mrg_data(mrg_data), .shift_amt(shift_amt),
    .fld_lo(fld_lo), .fld_hi(fld_hi), .fld_ext(fld_ext),
    .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [127:0] ref_move(bit wide, logic [127:0] a, logic [127:0] b,
                                            logic signed [7:0] sh, logic [5:0] lo,
                                            logic [5:0] hi, bit ext);
    logic [127:0] r;
    int width, lo_i, hi_i, j;
    bit wrap, sb, m;
    width = wide ? 128 : 64;
    wrap = 1'b0;
    if (!wide) begin
      lo_i = int'(lo); hi_i = int'(hi); wrap = (hi < lo);
    end else if (hi >= lo) begin
      lo_i = int'(lo) + (ext ? 64 : 0); hi_i = int'(hi) + (ext ? 64 : 0);
    end else begin
      lo_i = int'(lo); hi_i = int'(hi) + (ext ? 64 : 0);
    end
    r = '0;
    for (int i = 0; i < 128; i++) begin
      if (i < width) begin
        j  = i - int'(sh);
        sb = (j >= 0 && j < width) ? a[j] : 1'b0;
        m  = wrap ? (i >= lo_i || i < hi_i) : (i >= lo_i && i < hi_i);
        r[i] = m ? sb : b[i];
      end
    end
    return r;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(bit wide, logic [127:0] a, logic [127:0] b, logic [7:0] sh,
                       logic [5:0] lo, logic [5:0] hi, bit ext, string tag);
    @(negedge clk);
    op_valid  = 1'b1; wide_mode = wide; src_data = a; mrg_data = b;
    shift_amt = sh;   fld_lo = lo;      fld_hi = hi;  fld_ext = ext;
    exp_q.push_back(ref_move(wide, a, b, sh, lo, hi, ext));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      op_valid = 1'b0;
      src_data = {4{$urandom}};
    end
  endtask

  // monitor: pop and compare
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 unexpected result act=%h exp=none", res_data);
      end else begin
        last_exp = exp_q.pop_front();
        check(tag_q.pop_front(), res_data, last_exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog act=%0d exp=<100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [127:0] PAT_A = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;
  localparam logic [127:0] PAT_B = 128'h1357_9BDF_2468_ACE0_FEDC_BA98_7654_3210;
  localparam logic [127:0] ONES  = {128{1'b1}};

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset valid", {127'b0, res_valid}, 128'd0);
    check("R10 reset data", res_data, 128'd0);
    rst = 1'b0;

    // R3: relocate source 19..12 into 55..48
    drive(0, PAT_A, PAT_B, 8'd36, 6'd48, 6'd56, 0, "R3 move");
    // R3: extract 19..12 into zero
    drive(0, PAT_A, '0, 8'hF4, 6'd0, 6'd8, 0, "R3 extract");
    // R4: wrap mask 60..63 and 0..3
    drive(0, PAT_A, PAT_B, 8'd2, 6'd60, 6'd4, 0, "R4 wrap");
    // R4: high index 0 means through bit 63
    drive(0, PAT_A, PAT_B, 8'd0, 6'd56, 6'd0, 0, "R4 hi0");
    // R4 with R2: wrap mask over bits shifted out on the left
    drive(0, ONES, PAT_B, 8'd62, 6'd40, 6'd10, 0, "R4 R2 wrap shift");
    // R5: empty mask
    drive(0, PAT_A, PAT_B, 8'd5, 6'd20, 6'd20, 0, "R5 empty64");
    drive(1, PAT_A, PAT_B, 8'd5, 6'd33, 6'd33, 1, "R5 empty128");
    // R2: shift magnitude beyond width
    drive(0, PAT_A, PAT_B, 8'd100, 6'd0, 6'd0, 0, "R2 big64 empty");
    drive(0, ONES, PAT_B, 8'd64, 6'd1, 6'd0, 0, "R2 shift64 zero");
    drive(1, ONES, PAT_B, 8'h80, 6'd0, 6'd63, 1, "R2 shift-128 zero");
    drive(1, PAT_A, PAT_B, 8'hC1, 6'd0, 6'd63, 1, "R2 right wide");
    // R7: upper halves and ext ignored in 64-bit mode
    drive(0, PAT_A, PAT_B, 8'd8, 6'd4, 6'd44, 1, "R7 ignore upper");
    // R8: ext prepended to both
    drive(1, PAT_A, PAT_B, 8'd64, 6'd8, 6'd16, 1, "R8 ext both");
    drive(1, PAT_A, PAT_B, 8'd3, 6'd8, 6'd60, 0, "R8 ext zero");
    // R9: ext on high only
    drive(1, PAT_A, PAT_B, 8'd7, 6'd40, 6'd8, 1, "R9 ext hi");
    drive(1, PAT_A, PAT_B, 8'd7, 6'd40, 6'd8, 0, "R9 empty");
    // R6: full-width merge
    drive(1, PAT_A, PAT_B, 8'd0, 6'd0, 6'd63, 1, "R6 wide merge");
    idle(3);
    // R1: idle holds last result
    check("R1 hold", res_data, last_exp);

    // R6: random mixed traffic with gaps
    for (int n = 0; n < 400; n++) begin
      drive($urandom % 2, {4{$urandom}}, {4{$urandom}}, 8'($urandom),
            6'($urandom), 6'($urandom), 1'($urandom), "R6 random");
      if ((n % 37) == 0) idle(2);
    end
    idle(3);
    check("R1 drained", 128'(exp_q.size()), 128'd0);
    check("R1 hold end", res_data, last_exp);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule